// File: doc/BRIEF.md
# Memory Sleep Mode Controller

This block sequences a synchronous memory into and out of a low-power sleep state. A sleep request arrives on a pin that has no timing relation to the clock. The request is passed through a two-flop synchronizer. It then drives a four-state sequencer: awake, entering, sleep and exiting. The sequencer takes a fixed number of cycles to go down and a fixed number of cycles to come back up. Core accesses are enabled only while the block is fully awake. The same gate keeps the data outputs undriven.

When entry begins, the block flags any access that is still pending as abandoned for that cycle. Outside the awake state the chip selects and both address strobes must stay inactive, and the memory must already be deselected at the moment entry begins. If either rule is broken, the block raises a protocol error that holds until reset.

Top module: `mem_sleep_ctrl`

## Requirements
- R1: During and right after reset, `access_en` is 1, `asleep` is 0, `abort_pend` is 0 and `proto_err` is 0.
- R2: `sleep_req` reaches the sequencer through two flops. A level applied before rising edge k first changes the state at edge k+2. So with ENTER_CYC=2 a rise on `sleep_req` drops `access_en` after the third edge.
- R3: Once entry starts, the block stays in the entering state for exactly ENTER_CYC cycles (default 2), with `access_en`=0 and `asleep`=0. It then enters sleep, and `asleep`=1.
- R4: Once the synchronized request is low in sleep, the block stays in the exiting state for exactly EXIT_CYC cycles (default 2), with `asleep`=0 and `access_en`=0. It then returns to awake.
- R5: `access_en` is 1 exactly when the state is awake. It is 0 in entering, sleep and exiting.
- R6: `abort_pend` is 1 only in the single cycle in which the state is awake and the synchronized request is 1. This is the cycle that starts entry.
- R7: If any bit of `chip_sel` is 1 in the cycle that starts entry, `proto_err` becomes 1 at the next edge.
- R8: Any `chip_sel` bit, `addr_stb_a` or `addr_stb_b` at 1 while the state is not awake sets `proto_err` at the next edge.
- R9: Once set, `proto_err` stays 1 until `rst_n` is asserted low.
- R10: An entry or exit in progress always runs to completion. A request dropped during entering still reaches sleep and then exits. A request raised during exiting still returns to awake before a new entry begins.
- R11: `chip_sel` and the strobes have no effect on the state sequence. Activity on them during sleep leaves `asleep` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Sleep request, active high, asynchronous |
| chip_sel | input | NSEL | Chip selects, active high |
| addr_stb_a | input | 1 | First address strobe, active high |
| addr_stb_b | input | 1 | Second address strobe, active high |
| access_en | output | 1 | Core may decode cycles and drive data |
| asleep | output | 1 | Sleep state reached |
| abort_pend | output | 1 | Pending access abandoned this cycle |
| proto_err | output | 1 | Sticky protocol violation |

## Verification
The bench aims at the exact latency from a request edge to each state change. A synchronizer that is one flop short, or a counter that is off by one, moves `access_en` or `asleep` by a cycle. It also drops the request in the middle of entry and raises it again in the middle of exit. A design that cuts a sequence short in those cases would skip the sleep state or re-enter straight from exiting. It applies a select at the instant entry starts and strobes during sleep. A design that misses the select rule, or clears the error, would leave `proto_err` low.

// File: rtl/mem_sleep_ctrl.sv
module mem_sleep_ctrl #(
  parameter int NSEL      = 3,
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic [NSEL-1:0] chip_sel,
  input  logic            addr_stb_a,
  input  logic            addr_stb_b,
  output logic            access_en,
  output logic            asleep,
  output logic            abort_pend,
  output logic            proto_err
);
  localparam int MAXC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  typedef enum logic [1:0] {AWAKE, ENTERING, SLEEP, EXITING} st_t;

  st_t         state;
  logic [1:0]  sync;
  logic [CW-1:0] cnt;
  logic        req_s, any_act, busy;

  assign req_s      = sync[1];
  assign any_act    = (|chip_sel) | addr_stb_a | addr_stb_b;
  assign busy       = (state != AWAKE);
  assign access_en  = (state == AWAKE);
  assign asleep     = (state == SLEEP);
  assign abort_pend = (state == AWAKE) && req_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[0], sleep_req};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= AWAKE;
      cnt   <= '0;
    end else begin
      case (state)
        AWAKE:    if (req_s) begin state <= ENTERING; cnt <= CW'(ENTER_CYC - 1); end
        ENTERING: if (cnt == '0) state <= SLEEP; else cnt <= cnt - 1'b1;
        SLEEP:    if (!req_s) begin state <= EXITING; cnt <= CW'(EXIT_CYC - 1); end
        default:  if (cnt == '0) state <= AWAKE; else cnt <= cnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) proto_err <= 1'b0;
    else if ((busy && any_act) || (abort_pend && |chip_sel)) proto_err <= 1'b1;

  p_sleep_from_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(state == ENTERING));
  p_awake_from_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_en) |-> $past(state == EXITING));
  p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pend |=> !abort_pend);
  p_entry_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pend && |chip_sel) |=> proto_err);
  p_busy_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && any_act) |=> proto_err);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  p_no_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENTERING) |=> (state inside {ENTERING, SLEEP}));
endmodule

// File: tb/mem_sleep_ctrl_tb.sv
module mem_sleep_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSEL = 3;
  localparam int ENTER_CYC = 2;
  localparam int EXIT_CYC = 2;

  logic clk = 0, rst_n = 0, sleep_req = 0, addr_stb_a = 0, addr_stb_b = 0;
  logic [NSEL-1:0] chip_sel = '0;
  logic access_en, asleep, abort_pend, proto_err;
  int checks = 0, failures = 0;
  bit model_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_sleep_ctrl #(.NSEL(NSEL), .ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_sel(chip_sel),
    .addr_stb_a(addr_stb_a), .addr_stb_b(addr_stb_b), .access_en(access_en),
    .asleep(asleep), .abort_pend(abort_pend), .proto_err(proto_err));

  // reference: 0 awake, 1 entering, 2 sleep, 3 exiting
  logic m_s1, m_s2, m_err;
  int m_st, m_cnt;

  function automatic bit exp_en(int st); return st == 0; endfunction
  function automatic bit exp_sleep(int st); return st == 2; endfunction
  function automatic bit exp_abort(int st, bit s2); return st == 0 && s2; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_st <= 0; m_cnt <= 0; m_err <= 0;
    end else begin
      m_s1 <= sleep_req; m_s2 <= m_s1;
      if ((m_st != 0 && ((|chip_sel) || addr_stb_a || addr_stb_b)) ||
          (exp_abort(m_st, m_s2) && |chip_sel)) m_err <= 1;
      case (m_st)
        0: if (m_s2) begin m_st <= 1; m_cnt <= ENTER_CYC - 1; end
        1: if (m_cnt == 0) m_st <= 2; else m_cnt <= m_cnt - 1;
        2: if (!m_s2) begin m_st <= 3; m_cnt <= EXIT_CYC - 1; end
        default: if (m_cnt == 0) m_st <= 0; else m_cnt <= m_cnt - 1;
      endcase
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on && rst_n) begin
    check("R5 access_en", access_en, exp_en(m_st));
    check("R3 asleep", asleep, exp_sleep(m_st));
    check("R6 abort_pend", abort_pend, exp_abort(m_st, m_s2));
    check("R8 proto_err", proto_err, m_err);
  end

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; sleep_req = 0; chip_sel = '0; addr_stb_a = 0; addr_stb_b = 0;
    edges(2); rst_n = 1; edges(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    edges(2);
    check("R1 en", access_en, 1); check("R1 asleep", asleep, 0);
    check("R1 abort", abort_pend, 0); check("R1 err", proto_err, 0);
    rst_n = 1; edges(1);
    check("R1 en after release", access_en, 1);
    model_on = 1;

    // R2/R3 entry latency
    sleep_req = 1; edges(2);
    check("R2 still awake", access_en, 1); check("R6 abort", abort_pend, 1);
    edges(1);
    check("R2 entering", access_en, 0); check("R3 not asleep yet", asleep, 0);
    edges(1); check("R3 entering 2nd", asleep, 0);
    edges(1); check("R3 asleep", asleep, 1);
    // R11 activity during sleep
    for (int i = 0; i < 6; i++) begin
      chip_sel = NSEL'($urandom); addr_stb_a = 1'($urandom); addr_stb_b = 1;
      edges(1); check("R11 stays asleep", asleep, 1);
    end
    chip_sel = '0; addr_stb_a = 0; addr_stb_b = 0;
    check("R8 err after strobes", proto_err, 1);
    // R4 exit latency
    sleep_req = 0; edges(2); check("R4 sleep held", asleep, 1);
    edges(1); check("R4 exiting", asleep, 0); check("R4 exiting en", access_en, 0);
    edges(1); check("R4 exiting 2nd", access_en, 0);
    edges(1); check("R4 awake", access_en, 1);
    check("R9 sticky", proto_err, 1);
    edges(5); check("R9 sticky later", proto_err, 1);

    // R10 drop during entering
    do_reset(); check("R1 cleared err", proto_err, 0);
    sleep_req = 1; edges(3); sleep_req = 0;
    edges(2); check("R10 reaches sleep", asleep, 1);
    edges(3); check("R10 back awake", access_en, 1);
    check("R10 clean err", proto_err, 0);
    // R10 raise during exiting
    sleep_req = 1; edges(5); sleep_req = 0; edges(3);
    sleep_req = 1; edges(2); check("R10 exit completes", access_en, 1);
    edges(1); check("R10 re-enter", access_en, 0);
    sleep_req = 0; edges(12);

    // R7 selected at entry
    do_reset();
    chip_sel = 3'b010; sleep_req = 1; edges(2);
    check("R7 no err before", proto_err, 0);
    chip_sel = 3'b010; edges(1); chip_sel = '0;
    check("R7 err on selected entry", proto_err, 1);
    sleep_req = 0; edges(10);

    // random phase
    for (int blk = 0; blk < 6; blk++) begin
      do_reset();
      for (int c = 0; c < 500; c++) begin
        if ($urandom_range(19) == 0) sleep_req = ~sleep_req;
        chip_sel = ($urandom_range(49) == 0) ? NSEL'($urandom) : '0;
        addr_stb_a = ($urandom_range(79) == 0);
        addr_stb_b = ($urandom_range(79) == 0);
        edges(1);
      end
    end
    model_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule